// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer for 9-bit words. It has a write port and a read port, each on its own clock. A word is accepted on a write-clock edge while the active-low write enable is asserted and the buffer is not full. A word is delivered into an output register on a read-clock edge while the active-low read enable is asserted and the buffer is not empty. Enables that arrive while the matching flag blocks them are dropped. Stored words are therefore never overwritten, and the output never advances past the newest word.

Four active-low status flags are driven, each from a register:
- empty and almost-empty in the read clock domain;
- full and almost-full in the write clock domain.

The almost flags compare the fill level with two thresholds held in a small threshold register bank. That bank resets to 7 and is loaded through a strobe, a select bit and a data field on the write clock. Pointers cross between the clock domains as Gray codes through two-flop synchronisers. A transfer on one side therefore reaches the other side's flags after a fixed synchroniser delay.

An active-low output enable either passes the output register to the data outputs or forces them to zero. A separate qualifier output shows which of the two is happening. Reset is synchronous and active high, and it is applied in both clock domains.

Top module: `fifo_pf`

## Requirements
- R1: A word on `din` is stored on a rising `wclk` edge only when `wen_n` is 0 and `full_n` is 1. Words come out in the order they were stored.
- R2: On a rising `rclk` edge where `ren_n` is 0 and `empty_n` is 1, the oldest stored word is loaded into the output register and is visible on `q` after that edge.
- R3: A write attempted while `full_n` is 0 is dropped: the stored contents and the write pointer are unchanged.
- R4: A read attempted while `empty_n` is 0 is dropped: the output register keeps the last word read.
- R5: While `rst` is 1 at a clock edge, no transfer takes place. After that edge, `empty_n` and `pae_n` are 0, `full_n` and `paf_n` are 1, and the output register holds zero.
- R6: `pae_n` is 0 exactly when the fill level seen by the read side is less than or equal to the empty threshold.
- R7: `paf_n` is 0 exactly when the free space seen by the write side (depth minus fill level) is less than or equal to the full threshold.
- R8: Both thresholds are 7 after reset. On a rising `wclk` edge with `ofs_ld_n` = 0, `ofs_data` is loaded into the empty threshold when `ofs_sel` = 0, or into the full threshold when `ofs_sel` = 1. Flags computed on that same edge still use the old value.
- R9: When `oe_n` is 1, `q` is all zeros and `q_en` is 0. When `oe_n` is 0, `q` carries the output register and `q_en` is 1.
- R10: When both clocks come from one source, a write on edge k first shows on `empty_n`/`pae_n` after edge k+3. In the same way, a read on edge k first shows on `full_n`/`paf_n` after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| wen_n | input | 1 | Write request, active low |
| din | input | DATA_W | Word to store |
| ren_n | input | 1 | Read request, active low |
| oe_n | input | 1 | Output enable, active low |
| ofs_ld_n | input | 1 | Threshold load strobe, active low, on `wclk` |
| ofs_sel | input | 1 | Threshold select: 0 = empty threshold, 1 = full threshold |
| ofs_data | input | ADDR_W+1 | Threshold value to load |
| q | output | DATA_W | Output word, or zero while disabled |
| q_en | output | 1 | High while `q` carries the output register |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |

## Verification
The assertions check on every cycle that:
- the write side's view of the fill level never exceeds the depth;
- the read pointer never passes the synchronised write pointer;
- pointers stay put when a request meets a blocking flag;
- the output register holds when no read fires;
- empty implies almost-empty, and full implies almost-full;
- reset leaves the read side empty.

Word ordering, the exact three-edge flag latency, the threshold values and their load timing, and the output-enable gating can only be shown by the bench's scenarios. In those scenarios, a queue-based model runs alongside the design with both clocks tied to one source.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;

  typedef enum logic {
    THR_EMPTY = 1'b0,
    THR_FULL  = 1'b1
  } thr_sel_e;

  // Binary to reflected Gray code; callers zero-extend and truncate.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary (prefix XOR from the top bit).
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/fifo_pf_sync.sv
module fifo_pf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fifo_pf_mem.sv
module fifo_pf_mem #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rst,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  // Registered read port; the register is cleared by reset.
  always_ff @(posedge rclk) begin
    if (rst)     dout <= '0;
    else if (re) dout <= store[raddr];
  end

  // The output register only moves on an accepted read.
  assert_hold_when_idle_R4: assert property (
    @(posedge rclk) disable iff (rst) !re |=> $stable(dout))
    else $error("output register changed without a read");
endmodule

// File: rtl/fifo_pf_thr.sv
module fifo_pf_thr
  import fifo_pf_pkg::*;
#(
  parameter int CW      = 5,
  parameter int DEF_THR = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_n,
  input  logic          sel,
  input  logic [CW-1:0] data,
  output logic [CW-1:0] empty_thr,
  output logic [CW-1:0] full_thr
);
  for (genvar i = 0; i < 2; i++) begin : g_thr
    logic [CW-1:0] val;
    always_ff @(posedge clk) begin
      if (rst)                            val <= CW'(DEF_THR);
      else if (!ld_n && (sel == 1'(i)))   val <= data;
    end
  end

  assign empty_thr = g_thr[THR_EMPTY].val;
  assign full_thr  = g_thr[THR_FULL].val;
endmodule

// File: rtl/fifo_pf_wside.sv
module fifo_pf_wside
  import fifo_pf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              rst,
  input  logic              wen_n,
  input  logic [ADDR_W:0]   rgray_sync,
  input  logic [ADDR_W:0]   full_thr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray,
  output logic              full_n,
  output logic              paf_n
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1 << ADDR_W);

  logic [CNT_W-1:0] wptr, wnext, rsync_bin, used_next, free_next;

  assign we        = !wen_n && full_n;
  assign wnext     = wptr + CNT_W'(we);
  assign rsync_bin = CNT_W'(from_gray(32'(rgray_sync)));
  assign used_next = wnext - rsync_bin;
  assign free_next = DEPTH_C - used_next;
  assign waddr     = wptr[ADDR_W-1:0];

  always_ff @(posedge wclk) begin
    if (rst) begin
      wptr   <= '0;
      wgray  <= '0;
      full_n <= 1'b1;
      paf_n  <= 1'b1;
    end else begin
      wptr   <= wnext;
      wgray  <= CNT_W'(to_gray(32'(wnext)));
      full_n <= (used_next != DEPTH_C);
      paf_n  <= !(free_next <= full_thr);
    end
  end

  assert_no_overflow_R3: assert property (
    @(posedge wclk) disable iff (rst) (wptr - rsync_bin) <= DEPTH_C)
    else $error("write side fill level beyond depth");

  assert_blocked_write_R3: assert property (
    @(posedge wclk) disable iff (rst) (!full_n && !wen_n) |=> $stable(wptr))
    else $error("write pointer moved while full");

  assert_full_implies_af_R7: assert property (
    @(posedge wclk) disable iff (rst) !full_n |-> !paf_n)
    else $error("full without almost-full");
endmodule

// File: rtl/fifo_pf_rside.sv
module fifo_pf_rside
  import fifo_pf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              rclk,
  input  logic              rst,
  input  logic              ren_n,
  input  logic [ADDR_W:0]   wgray_sync,
  input  logic [ADDR_W:0]   empty_thr,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic              empty_n,
  output logic              pae_n
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1 << ADDR_W);

  logic [CNT_W-1:0] rptr, rnext, wsync_bin, used_next;

  assign re        = !ren_n && empty_n;
  assign rnext     = rptr + CNT_W'(re);
  assign wsync_bin = CNT_W'(from_gray(32'(wgray_sync)));
  assign used_next = wsync_bin - rnext;
  assign raddr     = rptr[ADDR_W-1:0];

  always_ff @(posedge rclk) begin
    if (rst) begin
      rptr    <= '0;
      rgray   <= '0;
      empty_n <= 1'b0;
      pae_n   <= 1'b0;
    end else begin
      rptr    <= rnext;
      rgray   <= CNT_W'(to_gray(32'(rnext)));
      empty_n <= (rnext != wsync_bin);
      pae_n   <= !(used_next <= empty_thr);
    end
  end

  assert_no_underflow_R4: assert property (
    @(posedge rclk) disable iff (rst) (wsync_bin - rptr) <= DEPTH_C)
    else $error("read pointer passed the write pointer");

  assert_blocked_read_R4: assert property (
    @(posedge rclk) disable iff (rst) (!empty_n && !ren_n) |=> $stable(rptr))
    else $error("read pointer moved while empty");

  assert_empty_implies_ae_R6: assert property (
    @(posedge rclk) disable iff (rst) !empty_n |-> !pae_n)
    else $error("empty without almost-empty");

  assert_reset_empty_R5: assert property (
    @(posedge rclk) rst |=> (!empty_n && !pae_n && rptr == '0))
    else $error("reset did not leave the read side empty");
endmodule

// File: rtl/fifo_pf.sv
module fifo_pf
  import fifo_pf_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int ADDR_W  = 4,
  parameter int DEF_THR = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst,
  input  logic              wen_n,
  input  logic [DATA_W-1:0] din,
  input  logic              ren_n,
  input  logic              oe_n,
  input  logic              ofs_ld_n,
  input  logic              ofs_sel,
  input  logic [ADDR_W:0]   ofs_data,
  output logic [DATA_W-1:0] q,
  output logic              q_en,
  output logic              empty_n,
  output logic              full_n,
  output logic              pae_n,
  output logic              paf_n
);
  localparam int CNT_W = ADDR_W + 1;

  logic              we, re;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [CNT_W-1:0]  wgray, rgray, wgray_rs, rgray_ws;
  logic [CNT_W-1:0]  empty_thr, full_thr;
  logic [DATA_W-1:0] q_reg;

  fifo_pf_thr #(.CW(CNT_W), .DEF_THR(DEF_THR)) u_thr (
    .clk(wclk), .rst(rst), .ld_n(ofs_ld_n), .sel(ofs_sel), .data(ofs_data),
    .empty_thr(empty_thr), .full_thr(full_thr));

  fifo_pf_wside #(.ADDR_W(ADDR_W)) u_wside (
    .wclk(wclk), .rst(rst), .wen_n(wen_n), .rgray_sync(rgray_ws),
    .full_thr(full_thr), .we(we), .waddr(waddr), .wgray(wgray),
    .full_n(full_n), .paf_n(paf_n));

  fifo_pf_rside #(.ADDR_W(ADDR_W)) u_rside (
    .rclk(rclk), .rst(rst), .ren_n(ren_n), .wgray_sync(wgray_rs),
    .empty_thr(empty_thr), .re(re), .raddr(raddr), .rgray(rgray),
    .empty_n(empty_n), .pae_n(pae_n));

  fifo_pf_sync #(.W(CNT_W)) u_sync_w2r (
    .clk(rclk), .rst(rst), .d(wgray), .q(wgray_rs));

  fifo_pf_sync #(.W(CNT_W)) u_sync_r2w (
    .clk(wclk), .rst(rst), .d(rgray), .q(rgray_ws));

  fifo_pf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
    .rclk(rclk), .rst(rst), .re(re), .raddr(raddr), .dout(q_reg));

  assign q_en = !oe_n;
  assign q    = oe_n ? '0 : q_reg;
endmodule

// File: tb/fifo_pf_tb.sv
module fifo_pf_tb;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wen_n = 1'b0, ren_n = 1'b0, oe_n = 1'b0;
  logic ofs_ld_n = 1'b1, ofs_sel = 1'b0;
  logic [AW:0] ofs_data = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] q;
  logic q_en, empty_n, full_n, pae_n, paf_n;

  int checks = 0, failures = 0, cyc = 0;
  bit started = 1'b0;

  always #10 clk = ~clk;

  fifo_pf #(.DATA_W(DW), .ADDR_W(AW), .DEF_THR(7)) u_dut (
    .wclk(clk), .rclk(clk), .rst(rst), .wen_n(wen_n), .din(din),
    .ren_n(ren_n), .oe_n(oe_n), .ofs_ld_n(ofs_ld_n), .ofs_sel(ofs_sel),
    .ofs_data(ofs_data), .q(q), .q_en(q_en), .empty_n(empty_n),
    .full_n(full_n), .pae_n(pae_n), .paf_n(paf_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: queue of words, transfer totals, delayed views.
  int fifo_q[$];
  int wc, rc, w1, w2, w3, r1, r2, r3, ethr, fthr, q_m;
  bit m_empty_n, m_full_n, m_pae_n, m_paf_n;

  always @(posedge clk) begin
    cyc++;
    started = 1'b1;
    if (rst) begin
      fifo_q.delete();
      wc = 0; rc = 0; w1 = 0; w2 = 0; w3 = 0; r1 = 0; r2 = 0; r3 = 0;
      ethr = 7; fthr = 7; q_m = 0;
      m_empty_n = 0; m_full_n = 1; m_pae_n = 0; m_paf_n = 1;
    end else begin
      bit wr, rd;
      wr = !wen_n && m_full_n;
      rd = !ren_n && m_empty_n;
      if (wr) fifo_q.push_back(int'(din));
      if (rd) q_m = fifo_q.pop_front();
      w3 = w2; w2 = w1; w1 = wc;
      r3 = r2; r2 = r1; r1 = rc;
      wc += int'(wr);
      rc += int'(rd);
      m_empty_n = (w3 != rc);
      m_full_n  = ((wc - r3) != DEPTH);
      m_pae_n   = !((w3 - rc) <= ethr);
      m_paf_n   = !((DEPTH - (wc - r3)) <= fthr);
      if (!ofs_ld_n) begin
        if (ofs_sel) fthr = int'(ofs_data);
        else         ethr = int'(ofs_data);
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(empty_n === m_empty_n, "R2 R10 empty_n", int'(empty_n), int'(m_empty_n));
      chk(full_n === m_full_n, "R3 R10 full_n", int'(full_n), int'(m_full_n));
      chk(pae_n === m_pae_n, "R6 pae_n", int'(pae_n), int'(m_pae_n));
      chk(paf_n === m_paf_n, "R7 paf_n", int'(paf_n), int'(m_paf_n));
      chk(q === DW'(oe_n ? 0 : q_m), "R1 R2 R4 R9 q", int'(q), oe_n ? 0 : q_m);
      chk(q_en === !oe_n, "R9 q_en", int'(q_en), int'(!oe_n));
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wen_n = 1'b0; ren_n = 1'b0;
    step(4);
    wen_n = 1'b1; ren_n = 1'b1;
    rst = 1'b0;
  endtask

  task automatic push(input int n, input int seed);
    wen_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      din = DW'(seed + i * 37);
      step();
    end
    wen_n = 1'b1;
  endtask

  initial begin
    step(1);
    do_reset();
    @(negedge clk);
    // R5: requests held low during reset had no effect
    chk(empty_n === 1'b0, "R5 empty_n after reset", int'(empty_n), 0);
    chk(full_n === 1'b1, "R5 full_n after reset", int'(full_n), 1);
    chk(q === '0, "R5 q after reset", int'(q), 0);
    step(1);

    // R10: three-edge latency of a write reaching the read-side flags
    wen_n = 1'b0; din = 9'h1a5;
    @(posedge clk); #5; wen_n = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(empty_n === 1'b0, "R10 empty_n after k+2", int'(empty_n), 0);
    @(negedge clk);
    chk(empty_n === 1'b1, "R10 empty_n after k+3", int'(empty_n), 1);
    step(1);

    // R1, R3: fill past the depth, extra writes dropped
    push(20, 11);
    step(5);
    chk(full_n === 1'b0, "R3 full_n when full", int'(full_n), 0);
    chk(paf_n === 1'b0, "R7 paf_n when full", int'(paf_n), 0);

    // R2, R4: drain past empty; output holds the last word
    ren_n = 1'b0; step(25); ren_n = 1'b1;
    step(3);
    chk(q === DW'(11 + 14 * 37), "R4 q holds last word", int'(q), (11 + 14 * 37) % 512);

    // R9: output enable gating
    oe_n = 1'b1; step(1);
    @(negedge clk);
    chk(q === '0 && q_en === 1'b0, "R9 q forced idle", int'(q), 0);
    step(2); oe_n = 1'b0;

    // Streaming with interleaved enables
    for (int i = 0; i < 80; i++) begin
      wen_n = (i % 3 == 2);
      ren_n = (i % 4 == 0) || (i < 10);
      din = DW'(i * 13 + 5);
      step();
    end
    wen_n = 1'b1; ren_n = 1'b1; step(6);
    ren_n = 1'b0; step(20); ren_n = 1'b1; step(4);

    // R8: defaults of 7 after reset
    do_reset();
    push(7, 100); step(5);
    chk(pae_n === 1'b0, "R8 pae_n at level 7 with default", int'(pae_n), 0);
    push(1, 200); step(5);
    chk(pae_n === 1'b1, "R8 pae_n at level 8 with default", int'(pae_n), 1);
    chk(paf_n === 1'b1, "R8 paf_n at free 8 with default", int'(paf_n), 1);
    push(1, 300); step(5);
    chk(paf_n === 1'b0, "R8 paf_n at free 7 with default", int'(paf_n), 0);

    // R8: load new thresholds (empty 2, full 3), then sweep levels
    ofs_ld_n = 1'b0; ofs_sel = 1'b0; ofs_data = 5'd2; step();
    ofs_sel = 1'b1; ofs_data = 5'd3; step();
    ofs_ld_n = 1'b1; step(4);
    chk(pae_n === 1'b1, "R6 pae_n level 9 above threshold 2", int'(pae_n), 1);
    chk(paf_n === 1'b1, "R7 paf_n free 7 above threshold 3", int'(paf_n), 1);
    for (int i = 0; i < 8; i++) begin
      push(1, 400 + i); step(4);
    end
    ren_n = 1'b0;
    for (int i = 0; i < 18; i++) begin
      step(1); ren_n = 1'b1; step(3); ren_n = 1'b0;
    end
    ren_n = 1'b1; step(5);

    // Reset again mid-content
    push(5, 50);
    do_reset();
    step(3);
    @(negedge clk);
    chk(empty_n === 1'b0, "R5 empty_n after second reset", int'(empty_n), 0);
    chk(pae_n === 1'b0, "R5 pae_n after second reset", int'(pae_n), 0);
    step(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule